// File: doc/BRIEF.md
# Positional Bus and Interrupt Arbiter

This block is the central arbiter for a backplane with up to eight slots, where slot 0 sits nearest the arbiter. It does two jobs. It hands out bus mastership to one slot at a time, and a new owner is chosen only when the current bus cycle ends. It also takes vectored interrupts for the processor. Each slot requests an interrupt at one of four levels. The arbiter acknowledges the winning slot alone, and it latches the vector that slot presents, together with the level.

The choice of bus owner depends only on slot position: the requester nearest the arbiter always wins. For interrupts, the order has two steps. Only requests above the processor's current priority are considered. Among those, the highest level wins, and the nearer slot wins within that level. The acknowledge stays on until the requester drops its request. The vector captured when the acknowledge first rises stays stable for that whole time.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, bus_gnt_o, irq_ack_o and vec_vld_o are all zero. bus_gnt_o always has at most one bit set, and all zeros means no owner.
- R2: While no slot owns the bus, the lowest-indexed slot whose bus_req_i bit is high gets the grant at the next rising clock edge.
- R3: While a grant is active and cycle_done_i is low, bus_gnt_o does not change, even if a lower-indexed slot raises a request.
- R4: On an edge where a grant is active and cycle_done_i is high, the grant moves to the lowest-indexed slot requesting at that edge, or to zero if no slot is requesting.
- R5: An interrupt from slot k counts only when its level (irq_lvl_i bits [2k+1:2k], 0 to 3, 3 being the highest) is strictly greater than cpu_prio_i. Requests at or below cpu_prio_i produce no acknowledge.
- R6: Among the requests that count, the highest level wins, whatever the slot positions.
- R7: Among requests that count at the winning level, the lowest-indexed slot wins.
- R8: irq_ack_o is one-hot or zero. It rises one clock edge after a winner is present with no acknowledge outstanding. At that same edge, vec_o takes slot k's vector (irq_vec_i bits [9k+8:9k]) and vec_lvl_o takes the winning level. vec_vld_o is high exactly while an acknowledge is held.
- R9: The acknowledge holds while the acknowledged slot keeps its irq_req_i bit high, and vec_o stays constant even if irq_vec_i changes. The acknowledge clears at the first edge where that bit is low, and arbitration restarts at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 8 | Per-slot bus mastership request |
| cycle_done_i | input | 1 | Current bus cycle ends at this edge |
| bus_gnt_o | output | 8 | One-hot bus grant |
| irq_req_i | input | 8 | Per-slot interrupt request |
| irq_lvl_i | input | 16 | Per-slot interrupt level, 2 bits per slot |
| irq_vec_i | input | 72 | Per-slot interrupt vector, 9 bits per slot |
| cpu_prio_i | input | 2 | Processor current priority |
| irq_ack_o | output | 8 | One-hot interrupt acknowledge |
| vec_vld_o | output | 1 | Latched vector valid |
| vec_o | output | 9 | Latched vector of the acknowledged slot |
| vec_lvl_o | output | 2 | Level of the acknowledged interrupt |

## Verification
Bus arbitration is tried with scattered multi-slot request patterns, which separate lowest-index selection from any other order. A nearer slot is then raised in the middle of a cycle, which separates holding the grant from re-arbitrating too early. Interrupts are tried with mixes where a far slot has a higher level than a near slot, which separates level-first ordering from position-only ordering. Same-level groups check the position tie-break. A request equal to cpu_prio_i checks the strict comparison, and changing vectors under a held acknowledge checks the latch.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DEF_SLOTS  = 8;
  localparam int DEF_LEVELS = 4;
  localparam int DEF_VEC_W  = 9;
endpackage

// File: rtl/low_pick.sv
// Keeps only the lowest set bit: nearest slot wins.
module low_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] pick_o
);
  assign pick_o = req_i & (~req_i + W'(1));
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
  parameter int N_SLOTS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] bus_req_i,
  input  logic               cycle_done_i,
  output logic [N_SLOTS-1:0] bus_gnt_o
);
  logic [N_SLOTS-1:0] gnt_q, pick;
  logic               may_switch;

  low_pick #(.W(N_SLOTS)) u_pick (.req_i(bus_req_i), .pick_o(pick));

  // Switch only when idle or at end of the running cycle.
  assign may_switch = (gnt_q == '0) || cycle_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gnt_q <= '0;
    else if (may_switch) gnt_q <= pick;
  end

  assign bus_gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)); // R1
  AST_GNT_IDLE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q == '0 && bus_req_i != '0) |=> (gnt_q != '0)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0 && !cycle_done_i) |=> $stable(gnt_q)); // R3
  AST_GNT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_done_i && bus_req_i == '0) |=> (gnt_q == '0)); // R4
endmodule

// File: rtl/irq_fielder.sv
module irq_fielder #(
  parameter int N_SLOTS  = 8,
  parameter int N_LEVELS = 4,
  parameter int VEC_W    = 9,
  localparam int LVL_W   = $clog2(N_LEVELS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SLOTS-1:0]         irq_req_i,
  input  logic [N_SLOTS*LVL_W-1:0]   irq_lvl_i,
  input  logic [N_SLOTS*VEC_W-1:0]   irq_vec_i,
  input  logic [LVL_W-1:0]           cpu_prio_i,
  output logic [N_SLOTS-1:0]         irq_ack_o,
  output logic                       vec_vld_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic [LVL_W-1:0]           vec_lvl_o
);
  logic [N_SLOTS-1:0]  elig, at_best, win_oh, ack_q;
  logic [N_LEVELS-1:0] lvl_seen;
  logic [LVL_W-1:0]    best_lvl, lvl_q;
  logic [VEC_W-1:0]    win_vec, vec_q;
  logic                found, held_req;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign elig[k]    = irq_req_i[k] && (irq_lvl_i[k*LVL_W +: LVL_W] > cpu_prio_i);
    assign at_best[k] = elig[k] && (irq_lvl_i[k*LVL_W +: LVL_W] == best_lvl);
  end

  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    logic [N_SLOTS-1:0] on_lvl;
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_cmp
      assign on_lvl[k] = elig[k] && (irq_lvl_i[k*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvl_seen[l] = |on_lvl;
  end

  // Highest level present wins first.
  always_comb begin
    best_lvl = '0;
    for (int l = 0; l < N_LEVELS; l++)
      if (lvl_seen[l]) best_lvl = LVL_W'(l);
  end

  assign found = |elig;

  low_pick #(.W(N_SLOTS)) u_pick (.req_i(at_best), .pick_o(win_oh));

  always_comb begin
    win_vec = '0;
    for (int k = 0; k < N_SLOTS; k++)
      if (win_oh[k]) win_vec = win_vec | irq_vec_i[k*VEC_W +: VEC_W];
  end

  assign held_req = |(ack_q & irq_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= '0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (ack_q == '0) begin
      if (found) begin
        ack_q <= win_oh;
        vec_q <= win_vec;
        lvl_q <= best_lvl;
      end
    end else if (!held_req) begin
      ack_q <= '0;
    end
  end

  assign irq_ack_o = ack_q;
  assign vec_vld_o = |ack_q;
  assign vec_o     = vec_q;
  assign vec_lvl_o = lvl_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_q)); // R8
  AST_ACK_ABOVE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q == '0 && found) |=> (lvl_q > $past(cpu_prio_i))); // R5
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != '0 && held_req) |=> $stable(ack_q)); // R9
  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != '0 && held_req) |=> $stable(vec_q)); // R9
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != '0 && !held_req) |=> (ack_q == '0)); // R9
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import arb_pkg::*;
#(
  parameter int N_SLOTS  = DEF_SLOTS,
  parameter int N_LEVELS = DEF_LEVELS,
  parameter int VEC_W    = DEF_VEC_W,
  localparam int LVL_W   = $clog2(N_LEVELS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SLOTS-1:0]       bus_req_i,
  input  logic                     cycle_done_i,
  output logic [N_SLOTS-1:0]       bus_gnt_o,
  input  logic [N_SLOTS-1:0]       irq_req_i,
  input  logic [N_SLOTS*LVL_W-1:0] irq_lvl_i,
  input  logic [N_SLOTS*VEC_W-1:0] irq_vec_i,
  input  logic [LVL_W-1:0]         cpu_prio_i,
  output logic [N_SLOTS-1:0]       irq_ack_o,
  output logic                     vec_vld_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [LVL_W-1:0]         vec_lvl_o
);
  bus_grant_ctrl #(.N_SLOTS(N_SLOTS)) u_bus (
    .clk_i, .rst_ni, .bus_req_i, .cycle_done_i, .bus_gnt_o
  );

  irq_fielder #(.N_SLOTS(N_SLOTS), .N_LEVELS(N_LEVELS), .VEC_W(VEC_W)) u_irq (
    .clk_i, .rst_ni, .irq_req_i, .irq_lvl_i, .irq_vec_i, .cpu_prio_i,
    .irq_ack_o, .vec_vld_o, .vec_o, .vec_lvl_o
  );
endmodule

// File: tb/tb_slot_arbiter.sv
`timescale 1ns/1ps
module tb_slot_arbiter;
  logic        clk = 0, rst_ni = 0;
  logic [7:0]  bus_req = 0, irq_req = 0, gnt, ack;
  logic        cycle_done = 0, vld;
  logic [15:0] irq_lvl = 0;
  logic [71:0] irq_vec = 0;
  logic [1:0]  cpu_prio = 0, vlvl;
  logic [8:0]  vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  slot_arbiter dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req), .cycle_done_i(cycle_done),
    .bus_gnt_o(gnt), .irq_req_i(irq_req), .irq_lvl_i(irq_lvl), .irq_vec_i(irq_vec),
    .cpu_prio_i(cpu_prio), .irq_ack_o(ack), .vec_vld_o(vld), .vec_o(vec), .vec_lvl_o(vlvl)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_vecs(int base);
    for (int k = 0; k < 8; k++) irq_vec[k*9 +: 9] = 9'(base + 4*k);
  endtask

  task automatic set_lvl(int k, int l);
    irq_lvl[k*2 +: 2] = 2'(l);
  endtask

  task automatic t_reset;
    chk("R1 gnt after reset", 32'(gnt), 0);
    chk("R1 ack after reset", 32'(ack), 0);
    chk("R1 vld after reset", 32'(vld), 0);
  endtask

  task automatic t_bus;
    @(negedge clk) bus_req = 8'b1011_0100;
    @(negedge clk);
    chk("R2 idle pick lowest", 32'(gnt), 32'h04);
    bus_req = 8'b1011_0101;                 // nearer slot mid-cycle
    @(negedge clk);
    chk("R3 hold mid-cycle", 32'(gnt), 32'h04);
    @(negedge clk);
    chk("R3 hold second cycle", 32'(gnt), 32'h04);
    cycle_done = 1;
    @(negedge clk);
    chk("R4 handover nearest", 32'(gnt), 32'h01);
    chk("R1 one-hot", 32'($countones(gnt)), 1);
    bus_req = 8'b1000_0000;
    @(negedge clk);
    chk("R4 handover far slot", 32'(gnt), 32'h80);
    cycle_done = 0; bus_req = 0;
    @(negedge clk);
    chk("R3 held with request gone", 32'(gnt), 32'h80);
    cycle_done = 1;
    @(negedge clk);
    chk("R4 release to none", 32'(gnt), 0);
    cycle_done = 0;
  endtask

  task automatic t_irq_level;
    set_vecs(9'h100);
    cpu_prio = 1;
    set_lvl(2, 1); set_lvl(5, 2); set_lvl(6, 3);
    @(negedge clk) irq_req = 8'b0110_0100;
    @(negedge clk);
    chk("R6 highest level wins", 32'(ack), 32'h40);
    chk("R8 vector latched", 32'(vec), 32'h100 + 24);
    chk("R8 level latched", 32'(vlvl), 3);
    chk("R8 valid", 32'(vld), 1);
    irq_req = 8'b0010_0100;
    @(negedge clk);
    chk("R9 ack clears", 32'(ack), 0);
    chk("R8 valid drops", 32'(vld), 0);
    @(negedge clk);
    chk("R5 R6 next winner slot5", 32'(ack), 32'h20);
    chk("R8 vector slot5", 32'(vec), 32'h100 + 20);
    irq_req = 8'b0000_0100;
    @(negedge clk);
    @(negedge clk);
    chk("R5 level equal to prio ignored", 32'(ack), 0);
    @(negedge clk);
    chk("R5 still ignored", 32'(vld), 0);
    irq_req = 0;
  endtask

  task automatic t_irq_tie;
    cpu_prio = 0; irq_lvl = 0;
    set_lvl(1, 2); set_lvl(3, 2); set_lvl(7, 2); set_lvl(0, 1);
    @(negedge clk) irq_req = 8'b1000_1011;
    @(negedge clk);
    chk("R7 nearest in level", 32'(ack), 32'h02);
    chk("R7 vector slot1", 32'(vec), 32'h100 + 4);
    set_vecs(9'h040);
    irq_req = 8'b1000_1010;
    @(negedge clk);
    chk("R9 ack held", 32'(ack), 32'h02);
    chk("R9 vector stable", 32'(vec), 32'h100 + 4);
    irq_req = 8'b1000_1000;
    @(negedge clk);
    chk("R9 cleared", 32'(ack), 0);
    @(negedge clk);
    chk("R7 next in level", 32'(ack), 32'h08);
    chk("R8 fresh vector", 32'(vec), 32'h040 + 12);
    irq_req = 0;
    @(negedge clk);
    cpu_prio = 3; irq_lvl = 16'hFFFF; irq_req = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R5 top prio masks all", 32'(ack), 0);
    irq_req = 0; cpu_prio = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_ni = 1;
        @(negedge clk);
        t_bus();
        t_irq_level();
        t_irq_tie();
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule